// File: doc/BRIEF.md
# Stereo Serial Audio Receiver (Right-Justified / I2S)

This block turns a serial stereo audio stream into parallel samples. It takes a bit clock, a word clock and one data line and rebuilds 16-bit two's-complement words, sent MSB first. The block is clocked by the bit clock itself, and every input is sampled on its rising edge. A static select input chooses the framing. With select 0 the framing is right-justified: each word ends on the last bit before the word clock changes, and any leading bits beyond 16 are discarded. With select 1 the framing is I2S: the word starts one bit after the word-clock change, and bits after the sixteenth are ignored.

The left and right words of one frame are presented together, with a one-cycle pair-valid pulse once the right word is complete. A registered copy of the word clock is also brought out, so that logic further along can measure frame timing. There is one shift register for both framings. A small controller with five states decides when its contents are a finished word. PRIME loads the first word-clock sample after reset and always moves to HUNT. HUNT waits for the first word-clock change. On that change it goes to RJ_RUN when the select is 0, or to I2S_SHIFT when the select is 1. RJ_RUN stays in place and captures a word on every word-clock change. I2S_SHIFT counts bits. Its sixteenth bit captures a word and moves to I2S_WAIT, unless a word-clock change arrives in the same cycle, in which case it restarts in I2S_SHIFT. A change that arrives earlier also restarts I2S_SHIFT and drops the partial word. I2S_WAIT goes back to I2S_SHIFT on the next change.

Top module: `stereo_serial_rx`

## Requirements
- R1: While reset is asserted, left_o, right_o, pair_valid_o and lrck_sync_o are all 0.
- R2: Words are 16-bit two's complement and arrive MSB first. Full-scale codes 16'h7FFF and 16'h8000, as well as 16'hFFFF and 16'h0001, come out unchanged.
- R3: With fmt_i2s = 0, a word is the last 16 data bits sampled before a word-clock change. Words taken while the word clock was 1 are left, and words taken while it was 0 are right. Earlier bits in the same half are ignored.
- R4: With fmt_i2s = 1, a word is the data sampled on the 1st through 16th rising edges after the edge where a word-clock change is first seen (that edge counts as edge 0). Words that start while the word clock is 0 are left, and words that start while it is 1 are right. Later bits in the same half are ignored.
- R5: pair_valid_o is high for exactly one cycle per frame. It is seen after the rising edge that completes the right word: for fmt_i2s = 0 this is the edge where the word clock goes from 0 to 1, and for fmt_i2s = 1 it is edge 16 of the right half. left_o and right_o change only together with this pulse.
- R6: The first word-clock change after reset only synchronizes the block. A right word with no left word captured before it gives no pulse.
- R7: lrck_sync_o equals the word clock as sampled at the latest rising bit-clock edge after reset.
- R8: Frames of both 32 and 64 bit clocks are received correctly in both framings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_i2s | input | 1 | Framing select: 0 right-justified, 1 I2S |
| lrck | input | 1 | Word clock; one period carries one left and one right word |
| sdata | input | 1 | Serial audio data, MSB first |
| left_o | output | 16 | Left sample of the latest completed frame |
| right_o | output | 16 | Right sample of the latest completed frame |
| pair_valid_o | output | 1 | One-cycle pulse when a new left/right pair is presented |
| lrck_sync_o | output | 1 | Word clock registered on the bit clock |

## Verification
The hardest case to reach from the ports is I2S with 16 bits per half. There, the right word's LSB lands on the same edge as the next frame's word-clock change, so the block must capture a word and restart counting in one cycle. A second hard case is a stream that begins on a right half, which must produce no pulse. The stimulus builds each stream edge by edge. It fills the padding bits at random, then writes the words at the exact edge positions each framing requires. Runs with and without a leading right half are included, and the expected pulse edge is computed from the frame start.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

    typedef enum logic [2:0] {
        ST_PRIME     = 3'd0,
        ST_HUNT      = 3'd1,
        ST_RJ_RUN    = 3'd2,
        ST_I2S_SHIFT = 3'd3,
        ST_I2S_WAIT  = 3'd4
    } rx_state_e;

    typedef enum logic {
        FMT_RJ  = 1'b0,
        FMT_I2S = 1'b1
    } rx_fmt_e;

endpackage

// File: rtl/ssrx_wclk_edge.sv
module ssrx_wclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck_i,
    output logic lrck_q_o,
    output logic change_o
);

    logic lrck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lrck_q <= 1'b0;
        else        lrck_q <= lrck_i;
    end

    assign lrck_q_o = lrck_q;
    assign change_o = lrck_i ^ lrck_q;

endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] win_q_o,
    output logic [WORD_W-1:0] win_next_o
);

    logic [WORD_W-1:0] win_q;
    logic [WORD_W-1:0] win_d;

    // next window: every bit moves up one place, new bit enters at the bottom
    assign win_d[0] = sdata_i;
    for (genvar b = 1; b < WORD_W; b++) begin : g_shift
        assign win_d[b] = win_q[b-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win_q_o    = win_q;
    assign win_next_o = win_d;

endmodule

// File: rtl/ssrx_ctrl.sv
module ssrx_ctrl
    import ssrx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_i2s_i,
    input  logic              lrck_i,
    input  logic              lrck_q_i,
    input  logic              change_i,
    input  logic [WORD_W-1:0] win_q_i,
    input  logic [WORD_W-1:0] win_next_i,
    output logic              cap_valid_o,
    output logic              cap_left_o,
    output logic [WORD_W-1:0] cap_word_o
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             chan_q, chan_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
            chan_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            chan_q  <= chan_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        chan_d  = chan_q;
        unique case (state_q)
            ST_PRIME: begin
                state_d = ST_HUNT;
            end
            ST_HUNT: begin
                if (change_i) begin
                    chan_d  = lrck_i;
                    cnt_d   = '0;
                    state_d = (rx_fmt_e'(fmt_i2s_i) == FMT_I2S) ? ST_I2S_SHIFT : ST_RJ_RUN;
                end
            end
            ST_RJ_RUN: begin
                if (change_i) chan_d = lrck_i;
            end
            ST_I2S_SHIFT: begin
                if (change_i) begin
                    cnt_d  = '0;
                    chan_d = lrck_i;
                end else if (cnt_q == LAST_BIT) begin
                    cnt_d   = '0;
                    state_d = ST_I2S_WAIT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_I2S_WAIT: begin
                if (change_i) begin
                    cnt_d   = '0;
                    chan_d  = lrck_i;
                    state_d = ST_I2S_SHIFT;
                end
            end
            default: begin
                state_d = ST_HUNT;
            end
        endcase
    end

    // outputs
    always_comb begin
        cap_valid_o = 1'b0;
        cap_left_o  = 1'b0;
        cap_word_o  = win_q_i;
        unique case (state_q)
            ST_RJ_RUN: begin
                cap_valid_o = change_i;
                cap_left_o  = lrck_q_i;
                cap_word_o  = win_q_i;
            end
            ST_I2S_SHIFT: begin
                cap_valid_o = (cnt_q == LAST_BIT);
                cap_left_o  = ~chan_q;
                cap_word_o  = win_next_i;
            end
            default: begin
                cap_valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ssrx_pair.sv
module ssrx_pair #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid_i,
    input  logic              cap_left_i,
    input  logic [WORD_W-1:0] cap_word_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);

    logic [WORD_W-1:0] left_hold;
    logic              have_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold <= '0;
            have_left <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (cap_valid_i) begin
                if (cap_left_i) begin
                    left_hold <= cap_word_i;
                    have_left <= 1'b1;
                end else begin
                    have_left <= 1'b0;
                    if (have_left) begin
                        left_o  <= left_hold;
                        right_o <= cap_word_i;
                        valid_o <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
    parameter int WORD_W = 16
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              fmt_i2s,
    input  logic              lrck,
    input  logic              sdata,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              pair_valid_o,
    output logic              lrck_sync_o
);

    logic              lrck_q;
    logic              change;
    logic [WORD_W-1:0] win_q;
    logic [WORD_W-1:0] win_next;
    logic              cap_valid;
    logic              cap_left;
    logic [WORD_W-1:0] cap_word;

    ssrx_wclk_edge u_edge (
        .clk      (bclk),
        .rst_n    (rst_n),
        .lrck_i   (lrck),
        .lrck_q_o (lrck_q),
        .change_o (change)
    );

    ssrx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (bclk),
        .rst_n      (rst_n),
        .sdata_i    (sdata),
        .win_q_o    (win_q),
        .win_next_o (win_next)
    );

    ssrx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk         (bclk),
        .rst_n       (rst_n),
        .fmt_i2s_i   (fmt_i2s),
        .lrck_i      (lrck),
        .lrck_q_i    (lrck_q),
        .change_i    (change),
        .win_q_i     (win_q),
        .win_next_i  (win_next),
        .cap_valid_o (cap_valid),
        .cap_left_o  (cap_left),
        .cap_word_o  (cap_word)
    );

    ssrx_pair #(.WORD_W(WORD_W)) u_pair (
        .clk         (bclk),
        .rst_n       (rst_n),
        .cap_valid_i (cap_valid),
        .cap_left_i  (cap_left),
        .cap_word_i  (cap_word),
        .left_o      (left_o),
        .right_o     (right_o),
        .valid_o     (pair_valid_o)
    );

    assign lrck_sync_o = lrck_q;

endmodule

// File: rtl/stereo_serial_rx_chk.sv
module stereo_serial_rx_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lrck,
    input logic              fmt_i2s,
    input logic              pair_valid_o,
    input logic [WORD_W-1:0] left_o,
    input logic [WORD_W-1:0] right_o,
    input logic              lrck_sync_o
);

    logic seen;
    logic in_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    always_ff @(posedge clk) in_rst <= !rst_n;

    always @(posedge clk) begin
        if (!rst_n && in_rst) begin
            // R1
            reset_state_chk: assert (left_o == '0 && right_o == '0 && !pair_valid_o && !lrck_sync_o)
                else $error("reset state not clear");
        end
    end

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o);

    // R5
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && (left_o != $past(left_o) || right_o != $past(right_o))) |-> pair_valid_o);

    // R7
    wclk_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (lrck_sync_o == $past(lrck)));

    // R3
    rj_right_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && pair_valid_o && !fmt_i2s) |-> (lrck_sync_o && !$past(lrck_sync_o)));

endmodule

bind stereo_serial_rx stereo_serial_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (bclk),
    .rst_n        (rst_n),
    .lrck         (lrck),
    .fmt_i2s      (fmt_i2s),
    .pair_valid_o (pair_valid_o),
    .left_o       (left_o),
    .right_o      (right_o),
    .lrck_sync_o  (lrck_sync_o)
);

// File: tb/stereo_serial_rx_bench.sv
module stereo_serial_rx_bench;

    localparam int MAXE = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_i2s = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [15:0] left_o, right_o;
    logic        pair_valid_o, lrck_sync_o;

    int checks = 0;
    int failures = 0;

    bit          lr_s [MAXE];
    bit          dt_s [MAXE];
    int          n_edges;
    int          vtime [64];
    logic [15:0] vl [64];
    logic [15:0] vr [64];
    int          nv;

    always #2 clk = ~clk;

    stereo_serial_rx u_stereo_serial_rx (
        .bclk         (clk),
        .rst_n        (rst_n),
        .fmt_i2s      (fmt_i2s),
        .lrck         (lrck),
        .sdata        (sdata),
        .left_o       (left_o),
        .right_o      (right_o),
        .pair_valid_o (pair_valid_o),
        .lrck_sync_o  (lrck_sync_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pick(input int f, input bit dir, input bit right);
        if (dir && f == 0) return right ? 16'h8000 : 16'h7FFF;
        if (dir && f == 1) return right ? 16'h7FFF : 16'h8000;
        if (dir && f == 2) return right ? 16'h0001 : 16'hFFFF;
        return 16'($urandom);
    endfunction

    // lays out a stream edge by edge and the expected pairs with their edge index
    task automatic build(input bit fmt, input int n, input int nfr, input bit lead, input bit dir);
        int t = 0;
        int fs [8];
        bit lvl_l = fmt ? 1'b0 : 1'b1;
        nv = 0;
        for (int i = 0; i < 4; i++) begin
            lr_s[t] = lead ? lvl_l : ~lvl_l; dt_s[t] = 1'b0; t++;
        end
        if (lead) begin
            for (int i = 0; i < n; i++) begin
                lr_s[t] = ~lvl_l; dt_s[t] = 1'($urandom); t++;
            end
        end
        for (int f = 0; f < nfr; f++) begin
            fs[f] = t;
            for (int i = 0; i < 2*n; i++) begin
                lr_s[t] = (i < n) ? lvl_l : ~lvl_l; dt_s[t] = 1'($urandom); t++;
            end
        end
        for (int i = 0; i < n; i++) begin
            lr_s[t] = lvl_l; dt_s[t] = 1'($urandom); t++;
        end
        n_edges = t;
        for (int f = 0; f < nfr; f++) begin
            logic [15:0] lw = pick(f, dir, 1'b0);
            logic [15:0] rw = pick(f, dir, 1'b1);
            int s = fs[f];
            for (int j = 0; j < 16; j++) begin
                if (!fmt) begin
                    dt_s[s+n-16+j]   = lw[15-j];
                    dt_s[s+2*n-16+j] = rw[15-j];
                end else begin
                    dt_s[s+1+j]   = lw[15-j];
                    dt_s[s+n+1+j] = rw[15-j];
                end
            end
            vtime[nv] = fmt ? s + n + 16 : s + 2*n;
            vl[nv] = lw;
            vr[nv] = rw;
            nv++;
        end
    endtask

    task automatic run_stream(input bit fmt, input string tag);
        int vi = 0;
        rst_n = 1'b0;
        fmt_i2s = fmt;
        lrck = lr_s[0];
        sdata = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(left_o == 16'h0 && right_o == 16'h0, "R1", "outputs in reset", {left_o, right_o}, 32'h0);
        chk(!pair_valid_o && !lrck_sync_o, "R1", "valid/sync in reset", {pair_valid_o, lrck_sync_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < n_edges; t++) begin
            @(negedge clk);
            lrck = lr_s[t];
            sdata = dt_s[t];
            @(posedge clk);
            #1;
            // R7 registered word clock
            chk(lrck_sync_o == lr_s[t], "R7", "word clock copy", lrck_sync_o, lr_s[t]);
            if (vi < nv && t == vtime[vi]) begin
                chk(pair_valid_o, {tag, " R5"}, "pulse missing", pair_valid_o, 1);
                chk(left_o == vl[vi], {tag, " R2"}, "left word", left_o, vl[vi]);
                chk(right_o == vr[vi], {tag, " R2"}, "right word", right_o, vr[vi]);
                vi++;
            end else if (pair_valid_o) begin
                chk(1'b0, {tag, " R5 R6"}, "unexpected pulse", pair_valid_o, 0);
            end
        end
        chk(vi == nv, {tag, " R5"}, "pairs delivered", vi, nv);
    endtask

    initial begin
        void'($urandom(32'h5A3C));
        build(1'b0, 16, 6, 1'b0, 1'b1); run_stream(1'b0, "R3 R8 rj32");
        build(1'b0, 32, 6, 1'b0, 1'b1); run_stream(1'b0, "R3 R8 rj64");
        build(1'b1, 16, 6, 1'b0, 1'b1); run_stream(1'b1, "R4 R8 i2s32");
        build(1'b1, 32, 6, 1'b0, 1'b0); run_stream(1'b1, "R4 R8 i2s64");
        build(1'b0, 16, 4, 1'b1, 1'b0); run_stream(1'b0, "R6 R3 rjlead");
        build(1'b1, 32, 4, 1'b1, 1'b1); run_stream(1'b1, "R6 R4 i2slead");
        build(1'b1, 16, 4, 1'b1, 1'b0); run_stream(1'b1, "R6 R4 i2slead32");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R5 watchdog expired actual=150000 expected=<150000 cycles");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule